// File: doc/BRIEF.md
# ECC Read-Modify-Write Memory Controller

This controller sits between a host request port and a synchronous memory whose words are 72 bits wide. Each stored word holds 64 data bits and an 8-bit extended Hamming check field (seven position parity bits plus one overall parity bit). The code repairs any single flipped bit and flags any double flip. Reads pass through the decoder. The host gets corrected data and two status bits in the same cycle.

A write that covers all eight byte lanes is encoded and stored in one memory access. A write that covers fewer lanes cannot carry a valid check field on its own. The controller therefore fetches the stored word first, repairs a single-bit error in it, overlays the enabled bytes, encodes the result and writes the full word back. If the fetched word is uncorrectable, the write-back is cancelled and the host sees an abort pulse. A configuration input turns protection off. Byte writes then go straight to memory under a byte-lane mask, and reads return raw bits.

Top module: `ecc_rmw_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it falls, `req_ready` is 1 and `rsp_valid`, `wr_abort` and `mem_en` are all 0.
- R2: With protection on, a write with all eight `req_be` bits set issues exactly one memory write in the cycle after acceptance. That write has all nine `mem_wmask` lanes set and the accepted address, it issues no memory read, and `req_ready` stays 1.
- R3: A read accepted at edge E0 drives `rsp_valid` high for one cycle right after edge E0+2, and `req_ready` is 0 in the two cycles between. A clean word returns its data with `rsp_ce` = 0 and `rsp_ue` = 0.
- R4: With protection on, a stored word with any one of its 72 bits flipped reads back as the original data with `rsp_ce` = 1 and `rsp_ue` = 0, and the read issues no memory write.
- R5: With protection on, a stored word with two flipped bits reads back with `rsp_ue` = 1 and `rsp_ce` = 0.
- R6: With protection on, a write with at least one `req_be` bit clear issues one memory read, then one memory write with all nine mask lanes set. Afterwards the word reads back clean, with the enabled bytes taken from the write and the other bytes unchanged (byte b is bits 8b+7..8b).
- R7: A single-bit error in the word fetched for a partial write is repaired before the merge. A later read returns the merged data with both status bits 0, wherever the flipped bit was, including the check field.
- R8: When the word fetched for a partial write is uncorrectable, no memory write is issued and the stored word is left bit-for-bit unchanged. `wr_abort` pulses high for exactly one cycle.
- R9: With protection off, any write issues no memory read and exactly one memory write, with mask lanes 7..0 equal to `req_be` and lane 8 (check field) clear. Reads return the raw data bits with both status bits 0, even when bits have been flipped.
- R10: A stored word keeps the 64 data bits in memory bits 63..0 and the check field in bits 71..64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ecc_on | input | 1 | 1 enables encoding, correction and read-merge-write |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_we | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte-lane enables for writes |
| rsp_valid | output | 1 | Read response strobe, one cycle |
| rsp_data | output | DATA_W | Read data, corrected when protection is on |
| rsp_ce | output | 1 | A single-bit error was corrected |
| rsp_ue | output | 1 | An uncorrectable error was found |
| wr_abort | output | 1 | Partial write dropped because of an uncorrectable word |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W+8 | Data and check field to store |
| mem_wmask | output | DATA_W/8+1 | Byte-lane write mask; top lane covers the check field |
| mem_rdata | input | DATA_W+8 | Stored word, one cycle after a read strobe |

## Verification
In a partial write, error repair and byte merging happen in the same cycle. The fetched word is decoded and overlaid in the same cycle that produces the write-back. A table of partial writes flips a stored bit before each write. Some entries put the flip in a lane the write keeps, some in a lane it overwrites, and some in the check field or the overall parity bit. Other entries flip two bits so that the abort path is taken instead. Each outcome is judged from the memory traffic and by reading the word back: the merged value must come back with both status bits clear, or the old word must be untouched.

// File: rtl/ecc_rmw_pkg.sv
package ecc_rmw_pkg;

  // number of position-parity bits needed for dw data bits
  function automatic int chk_bits(input int dw);
    int p;
    p = 1;
    while ((1 << p) < dw + p + 1) p = p + 1;
    return p;
  endfunction

  // codeword position (1-based, skipping powers of two) of data bit idx
  function automatic int data_pos(input int idx);
    int cnt;
    int pos;
    cnt = 0;
    pos = 0;
    for (int q = 3; q < 4096; q++) begin
      if ((q & (q - 1)) != 0) begin
        if (cnt == idx) begin
          pos = q;
          break;
        end
        cnt++;
      end
    end
    return pos;
  endfunction

  // data bits covered by parity bit k
  function automatic logic [1023:0] cover_mask(input int dw, input int k);
    logic [1023:0] m;
    m = '0;
    for (int i = 0; i < dw; i++) m[i] = ((data_pos(i) >> k) & 1) != 0;
    return m;
  endfunction

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_CHECK} rmw_state_t;

endpackage

// File: rtl/ecc_enc.sv
module ecc_enc import ecc_rmw_pkg::*; #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0]           data,
  output logic [chk_bits(DATA_W):0]   chk
);
  localparam int P = chk_bits(DATA_W);

  logic [P-1:0] hpar;

  for (genvar k = 0; k < P; k++) begin : g_par
    localparam logic [1023:0] MK = cover_mask(DATA_W, k);
    assign hpar[k] = ^(data & MK[DATA_W-1:0]);
  end

  // overall parity makes the full stored word even
  assign chk = {^{hpar, data}, hpar};

endmodule

// File: rtl/ecc_dec.sv
module ecc_dec import ecc_rmw_pkg::*; #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W+chk_bits(DATA_W):0] word,
  output logic [DATA_W-1:0]                data_o,
  output logic                             ce,
  output logic                             ue
);
  localparam int P = chk_bits(DATA_W);
  localparam int N = DATA_W + P;   // highest valid syndrome

  logic [DATA_W-1:0] dat;
  logic [P-1:0]      hpar;
  logic [P-1:0]      syn;
  logic              odd;

  assign dat  = word[DATA_W-1:0];
  assign hpar = word[DATA_W +: P];
  assign odd  = ^word;

  for (genvar k = 0; k < P; k++) begin : g_syn
    localparam logic [1023:0] MK = cover_mask(DATA_W, k);
    assign syn[k] = (^(dat & MK[DATA_W-1:0])) ^ hpar[k];
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_fix
    localparam int DP = data_pos(i);
    assign data_o[i] = dat[i] ^ (odd && (int'(syn) == DP));
  end

  assign ce = odd && (int'(syn) <= N);
  assign ue = (!odd && (syn != '0)) || (odd && (int'(syn) > N));

endmodule

// File: rtl/ecc_merge.sv
module ecc_merge #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0]   old_data,
  input  logic [DATA_W-1:0]   new_data,
  input  logic [DATA_W/8-1:0] be,
  output logic [DATA_W-1:0]   merged
);
  localparam int NB = DATA_W / 8;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign merged[8*b +: 8] = be[b] ? new_data[8*b +: 8] : old_data[8*b +: 8];
  end

endmodule

// File: rtl/ecc_rmw_ctrl.sv
module ecc_rmw_ctrl import ecc_rmw_pkg::*; #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 10
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             ecc_on,
  input  logic                             req_valid,
  output logic                             req_ready,
  input  logic                             req_we,
  input  logic [ADDR_W-1:0]                req_addr,
  input  logic [DATA_W-1:0]                req_wdata,
  input  logic [DATA_W/8-1:0]              req_be,
  output logic                             rsp_valid,
  output logic [DATA_W-1:0]                rsp_data,
  output logic                             rsp_ce,
  output logic                             rsp_ue,
  output logic                             wr_abort,
  output logic                             mem_en,
  output logic                             mem_we,
  output logic [ADDR_W-1:0]                mem_addr,
  output logic [DATA_W+chk_bits(DATA_W):0] mem_wdata,
  output logic [DATA_W/8:0]                mem_wmask,
  input  logic [DATA_W+chk_bits(DATA_W):0] mem_rdata
);
  localparam int P  = chk_bits(DATA_W);
  localparam int NB = DATA_W / 8;

  rmw_state_t        st;
  logic              op_wr;
  logic              op_ecc;
  logic [DATA_W-1:0] op_data;
  logic [NB-1:0]     op_be;

  logic [DATA_W-1:0] fix_data;
  logic              fix_ce;
  logic              fix_ue;
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] enc_in;
  logic [P:0]        enc_chk;
  logic              accept;
  logic              direct_wr;

  ecc_dec #(.DATA_W(DATA_W)) u_dec (
    .word   (mem_rdata),
    .data_o (fix_data),
    .ce     (fix_ce),
    .ue     (fix_ue)
  );

  ecc_merge #(.DATA_W(DATA_W)) u_merge (
    .old_data (fix_data),
    .new_data (op_data),
    .be       (op_be),
    .merged   (merged)
  );

  // one encoder, shared by direct writes and write-backs
  assign enc_in = (st == ST_CHECK) ? merged : req_wdata;

  ecc_enc #(.DATA_W(DATA_W)) u_enc (
    .data (enc_in),
    .chk  (enc_chk)
  );

  assign req_ready = (st == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign direct_wr = req_we && ((&req_be) || !ecc_on);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      op_wr     <= 1'b0;
      op_ecc    <= 1'b0;
      op_data   <= '0;
      op_be     <= '0;
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_wmask <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_ce    <= 1'b0;
      rsp_ue    <= 1'b0;
      wr_abort  <= 1'b0;
    end else begin
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      rsp_valid <= 1'b0;
      wr_abort  <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (accept) begin
            mem_en   <= 1'b1;
            mem_addr <= req_addr;
            op_wr    <= req_we;
            op_ecc   <= ecc_on;
            op_data  <= req_wdata;
            op_be    <= req_be;
            if (direct_wr) begin
              mem_we    <= 1'b1;
              mem_wdata <= {enc_chk, req_wdata};
              mem_wmask <= ecc_on ? '1 : {1'b0, req_be};
            end else begin
              st <= ST_FETCH;
            end
          end
        end
        ST_FETCH: st <= ST_CHECK;
        ST_CHECK: begin
          st <= ST_IDLE;
          if (op_wr) begin
            if (fix_ue) begin
              wr_abort <= 1'b1;
            end else begin
              mem_en    <= 1'b1;
              mem_we    <= 1'b1;
              mem_wdata <= {enc_chk, merged};
              mem_wmask <= '1;
            end
          end else begin
            rsp_valid <= 1'b1;
            rsp_data  <= op_ecc ? fix_data : mem_rdata[DATA_W-1:0];
            rsp_ce    <= op_ecc && fix_ce;
            rsp_ue    <= op_ecc && fix_ue;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R2: protected full write goes out next cycle with every lane, no stall
  a_r2_full_write: assert property (@(posedge clk) disable iff (rst)
    (accept && req_we && (&req_be) && ecc_on) |=>
      (mem_en && mem_we && (&mem_wmask) && (mem_addr == $past(req_addr)) && req_ready));

  // R3: read response two cycles after acceptance
  a_r3_read_latency: assert property (@(posedge clk) disable iff (rst)
    (accept && !req_we) |=> (!req_ready && !rsp_valid) ##1 (!req_ready && !rsp_valid) ##1 rsp_valid);

  // R5: status bits never both set on a response
  a_r5_status_excl: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !(rsp_ce && rsp_ue));

  // R6: write-back of a read-merge-write covers the whole word
  a_r6_writeback_full: assert property (@(posedge clk) disable iff (rst)
    (mem_en && mem_we && $past(mem_en && !mem_we, 2)) |-> (&mem_wmask));

  // R8: abort follows a fetch and comes without a write
  a_r8_abort_nowrite: assert property (@(posedge clk) disable iff (rst)
    wr_abort |-> ($past(mem_en && !mem_we, 2) && !mem_en));

  // R9: unprotected writes never fetch and leave the check lane alone
  a_r9_raw_write: assert property (@(posedge clk) disable iff (rst)
    (accept && req_we && !ecc_on) |=> (mem_en && mem_we && !mem_wmask[NB] && req_ready));

endmodule

// File: tb/ecc_rmw_ctrl_test.sv
`timescale 1ns/1ps
module ecc_rmw_ctrl_test;
  localparam int DW = 64;
  localparam int AW = 10;
  localparam int CW = 72;
  localparam int NB = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ecc_on = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [NB-1:0] req_be = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic          rsp_ce;
  logic          rsp_ue;
  logic          wr_abort;
  logic          mem_en;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [CW-1:0] mem_wdata;
  logic [NB:0]   mem_wmask;
  logic [CW-1:0] mem_rdata;

  logic [CW-1:0] mem [0:(1<<AW)-1];

  int n_chk = 0;
  int n_err = 0;
  int n_wr = 0;
  int n_rd = 0;
  int n_ab = 0;
  logic [NB:0] last_mask = '0;

  always #2.5 clk = ~clk;

  ecc_rmw_ctrl #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .ecc_on(ecc_on),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ce(rsp_ce), .rsp_ue(rsp_ue),
    .wr_abort(wr_abort),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_wmask(mem_wmask), .mem_rdata(mem_rdata)
  );

  // synchronous memory model, one-cycle read latency
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        for (int b = 0; b < NB; b++)
          if (mem_wmask[b]) mem[mem_addr][8*b +: 8] <= mem_wdata[8*b +: 8];
        if (mem_wmask[NB]) mem[mem_addr][CW-1:DW] <= mem_wdata[CW-1:DW];
      end
      mem_rdata <= mem[mem_addr];
    end
  end

  always @(negedge clk) begin
    if (mem_en && mem_we) begin
      n_wr++;
      last_mask = mem_wmask;
    end
    if (mem_en && !mem_we) n_rd++;
    if (wr_abort) n_ab++;
  end

  // be, wdata, first flip, second flip (8'hFF = none)
  localparam logic [87:0] VEC [0:8] = '{
    {8'h0F, 64'h1111_2222_3333_4444, 8'hFF, 8'hFF},
    {8'hF0, 64'hDEAD_BEEF_0000_0000, 8'd3,  8'hFF},
    {8'hF0, 64'hCAFE_F00D_0000_0000, 8'd64, 8'hFF},
    {8'h01, 64'h0000_0000_0000_00AB, 8'd71, 8'hFF},
    {8'h0F, 64'h0000_0000_7777_8888, 8'd2,  8'hFF},
    {8'h3C, 64'h0000_5555_6666_0000, 8'd5,  8'd33},
    {8'h00, 64'hFFFF_FFFF_FFFF_FFFF, 8'd32, 8'hFF},
    {8'h80, 64'h9900_0000_0000_0000, 8'hFF, 8'hFF},
    {8'h0F, 64'h0000_0000_1234_5678, 8'd68, 8'd69}
  };

  task automatic chk(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] lane_mix(input logic [DW-1:0] o, input logic [DW-1:0] n,
                                             input logic [NB-1:0] be);
    logic [DW-1:0] r;
    for (int b = 0; b < NB; b++) r[8*b +: 8] = be[b] ? n[8*b +: 8] : o[8*b +: 8];
    return r;
  endfunction

  // returns at the negedge following the accepting edge
  task automatic issue(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic [NB-1:0] be);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_we    = we;
    req_addr  = a;
    req_wdata = d;
    req_be    = be;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic settle();
    while (!req_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic ce,
                         output logic ue, output int lat, output logic [1:0] rdy);
    int k;
    issue(1'b0, a, '0, '0);
    k = 0;
    rdy = 2'b11;
    while (!rsp_valid && k < 10) begin
      if (k < 2) rdy[k] = req_ready;
      @(negedge clk);
      k++;
    end
    d = rsp_data; ce = rsp_ce; ue = rsp_ue; lat = k;
    @(negedge clk);
    chk("R3 response one cycle wide", {71'b0, rsp_valid}, 72'd0);
    settle();
  endtask

  task automatic flip(input logic [AW-1:0] a, input int bitn);
    mem[a][bitn] = ~mem[a][bitn];
  endtask

  initial begin
    logic [DW-1:0] d;
    logic ce, ue;
    int lat;
    logic [1:0] rdy;
    int w0, r0, a0;
    logic [DW-1:0] base;
    logic [CW-1:0] snap;

    for (int i = 0; i < (1<<AW); i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    // R1: during reset
    chk("R1 ready in reset", {71'b0, req_ready}, 72'd1);
    chk("R1 outputs idle in reset", {69'b0, rsp_valid, wr_abort, mem_en}, 72'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready after reset", {71'b0, req_ready}, 72'd1);
    chk("R1 outputs idle after reset", {69'b0, rsp_valid, wr_abort, mem_en}, 72'd0);

    // R2 / R10: full protected write
    w0 = n_wr; r0 = n_rd;
    issue(1'b1, 10'd5, 64'h0BAD_CAFE_1234_5678, 8'hFF);
    chk("R2 ready held high", {71'b0, req_ready}, 72'd1);
    @(negedge clk);
    chk("R2 one write", 72'(n_wr - w0), 72'd1);
    chk("R2 no read", 72'(n_rd - r0), 72'd0);
    chk("R2 all lanes", 72'(last_mask), 72'h1FF);
    chk("R10 data field", 72'(mem[5][DW-1:0]), 72'h0BAD_CAFE_1234_5678);
    settle();

    // R3: clean read and timing
    do_read(10'd5, d, ce, ue, lat, rdy);
    chk("R3 latency", 72'(lat), 72'd2);
    chk("R3 ready low while busy", 72'(rdy), 72'd0);
    chk("R3 clean data", 72'(d), 72'h0BAD_CAFE_1234_5678);
    chk("R3 clean status", {70'b0, ce, ue}, 72'd0);

    // R4: every single-bit position
    base = 64'hF0E1_D2C3_B4A5_9687;
    issue(1'b1, 10'd100, base, 8'hFF);
    settle();
    for (int bn = 0; bn < CW; bn++) begin
      flip(10'd100, bn);
      w0 = n_wr;
      do_read(10'd100, d, ce, ue, lat, rdy);
      chk($sformatf("R4 data bit %0d", bn), 72'(d), 72'(base));
      chk($sformatf("R4 status bit %0d", bn), {70'b0, ce, ue}, 72'd2);
      chk($sformatf("R4 no write bit %0d", bn), 72'(n_wr - w0), 72'd0);
      flip(10'd100, bn);
    end

    // R5: double errors
    flip(10'd100, 0); flip(10'd100, 70);
    do_read(10'd100, d, ce, ue, lat, rdy);
    chk("R5 status data+check", {70'b0, ce, ue}, 72'd1);
    flip(10'd100, 0); flip(10'd100, 70);
    flip(10'd100, 64); flip(10'd100, 71);
    do_read(10'd100, d, ce, ue, lat, rdy);
    chk("R5 status check+overall", {70'b0, ce, ue}, 72'd1);
    flip(10'd100, 64); flip(10'd100, 71);

    // R6/R7/R8: partial write table
    for (int v = 0; v < 9; v++) begin
      logic [7:0] be, fa, fb;
      logic [DW-1:0] wd;
      logic [AW-1:0] a;
      {be, wd, fa, fb} = VEC[v];
      a = AW'(16 + v);
      base = 64'h0123_4567_89AB_CDEF ^ {8{8'(v * 17)}};
      issue(1'b1, a, base, 8'hFF);
      settle();
      if (fa != 8'hFF) flip(a, int'(fa));
      if (fb != 8'hFF) flip(a, int'(fb));
      snap = mem[a];
      w0 = n_wr; r0 = n_rd; a0 = n_ab;
      issue(1'b1, a, wd, be);
      settle();
      chk($sformatf("R6 fetch v%0d", v), 72'(n_rd - r0), 72'd1);
      if (fb != 8'hFF) begin
        chk($sformatf("R8 no write v%0d", v), 72'(n_wr - w0), 72'd0);
        chk($sformatf("R8 abort pulse v%0d", v), 72'(n_ab - a0), 72'd1);
        chk($sformatf("R8 memory unchanged v%0d", v), mem[a], snap);
      end else begin
        chk($sformatf("R6 one write v%0d", v), 72'(n_wr - w0), 72'd1);
        chk($sformatf("R6 full mask v%0d", v), 72'(last_mask), 72'h1FF);
        chk($sformatf("R6 no abort v%0d", v), 72'(n_ab - a0), 72'd0);
        do_read(a, d, ce, ue, lat, rdy);
        chk($sformatf("R7 merged data v%0d", v), 72'(d), 72'(lane_mix(base, wd, be)));
        chk($sformatf("R7 clean after merge v%0d", v), {70'b0, ce, ue}, 72'd0);
      end
    end

    // R9: protection off
    ecc_on = 1'b0;
    base = 64'h5A5A_A5A5_3C3C_C3C3;
    issue(1'b1, 10'd200, base, 8'hFF);
    settle();
    w0 = n_wr; r0 = n_rd;
    issue(1'b1, 10'd200, 64'h0000_0000_1357_9BDF, 8'h0F);
    settle();
    chk("R9 no fetch", 72'(n_rd - r0), 72'd0);
    chk("R9 one write", 72'(n_wr - w0), 72'd1);
    chk("R9 byte mask", 72'(last_mask), 72'h00F);
    flip(10'd200, 40);
    do_read(10'd200, d, ce, ue, lat, rdy);
    chk("R9 raw data", 72'(d), 72'(64'h5A5A_A4A5_1357_9BDF));
    chk("R9 status off", {70'b0, ce, ue}, 72'd0);
    ecc_on = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule